// File: doc/BRIEF.md
# Edge-Triggered Timer Capture with Chained Buffer

The block runs a free-running counter on the system clock and copies the counter into a primary capture register when a chosen transition appears on an external capture pin. The pin is asynchronous. It passes through a two-stage synchronizer. A two-state level tracker, with states `LVL_LOW` and `LVL_HIGH`, then follows the synchronized level. The transition `LVL_LOW -> LVL_HIGH` marks a rising edge and `LVL_HIGH -> LVL_LOW` marks a falling edge. A two-bit mode input picks which of these transitions fire a capture.

When chaining is enabled, each capture first pushes the old primary value into a secondary holding register, and then loads the new counter value into the primary register. Software reads either register through a read port. A full-width word read returns the whole value. A byte pair read returns the upper byte and latches the lower byte at the same moment, so the two halves always come from one sample. A clear input, driven by the power-state sequencer, empties both capture registers and the byte latch.

Top module: `cap_unit`

## Requirements
- R1: While `rst_n` is low, `cnt_val` is 0 and word reads of both the primary and the buffer register return 0.
- R2: `cnt_val` rises by one on every clock edge after reset and wraps from all-ones (0xFFFF) to 0.
- R3: With `edge_sel` 2'b00 or 2'b11, only a low-to-high transition of `cap_in` causes a capture.
- R4: With `edge_sel` 2'b01, both low-to-high and high-to-low transitions of `cap_in` cause a capture.
- R5: With `edge_sel` 2'b10, only a high-to-low transition of `cap_in` causes a capture.
- R6: A transition of `cap_in` that is set up before clock edge k updates the registers at edge k+2. The primary register then holds the `cnt_val` that was present just before edge k+2.
- R7: With `buf_en` = 1, a capture moves the previous primary value into the buffer register.
- R8: With `buf_en` = 0, a capture leaves the buffer register unchanged.
- R9: `clr_req` high at a clock edge sets the primary register, the buffer register and the byte latch to 0, and it overrides a capture at that same edge.
- R10: `rd_buf` selects the buffer (1) or the primary register (0). With `rd_byte` = 0, `rd_data` is the full selected value. With `rd_byte` = 1 and `rd_hi` = 1, `rd_data` is the upper byte in bits [7:0], with zeros above.
- R11: A clock edge with `rd_en`, `rd_byte` and `rd_hi` all high latches the lower byte of the selected register. Afterwards, `rd_byte` = 1 with `rd_hi` = 0 returns that latched byte in bits [7:0], even if a capture has since changed the register.
- R12: While `cap_in` holds its level, no capture occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_req | input | 1 | Synchronous clear of capture state from the power-state sequencer |
| cap_in | input | 1 | Asynchronous capture pin |
| edge_sel | input | 2 | Edge mode: 00/11 rising, 01 both, 10 falling |
| buf_en | input | 1 | Enables chaining of the primary register into the buffer register |
| rd_en | input | 1 | Read strobe (used by upper-byte reads to latch the lower byte) |
| rd_buf | input | 1 | Register select: 0 primary, 1 buffer |
| rd_byte | input | 1 | 0 full word, 1 byte access |
| rd_hi | input | 1 | Byte select during byte access: 1 upper, 0 latched lower |
| rd_data | output | 16 | Read data |
| cnt_val | output | 16 | Current free-running counter value |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and two synchronizer stages. At that width, the counter wraps after 65,536 cycles, so the bench can wait for the all-ones to zero rollover directly within its run time. Two synchronizer stages fix the capture latency at the edge k+2 timing, so the bench can predict each captured value from `cnt_val` alone.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE     = 2'b00,
        EDGE_BOTH     = 2'b01,
        EDGE_FALL     = 2'b10,
        EDGE_RISE_ALT = 2'b11
    } edge_mode_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/cap_edge_fsm.sv
module cap_edge_fsm
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  edge_mode_e mode,
    output logic       fire
);
    lvl_state_e state_q, state_d;
    logic       rise, fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (lvl) begin
                    state_d = LVL_HIGH;
                    rise    = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!lvl) begin
                    state_d = LVL_LOW;
                    fall    = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        unique case (mode)
            EDGE_RISE, EDGE_RISE_ALT: fire = rise;
            EDGE_BOTH:                fire = rise | fall;
            EDGE_FALL:                fire = fall;
        endcase
    end

    // R12: a capture always coincides with a level change of the tracker
    a_r12_fire_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> state_q != $past(state_q));
    // R5: falling mode fires only when the synchronized level is low
    a_r5_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == EDGE_FALL) |-> !lvl);
    // R3: rising modes fire only when the synchronized level is high
    a_r3_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (mode == EDGE_RISE || mode == EDGE_RISE_ALT)) |-> lvl);
endmodule

// File: rtl/cap_regs.sv
module cap_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fire,
    input  logic         buf_en,
    output logic [W-1:0] cnt,
    output logic [W-1:0] prim,
    output logic [W-1:0] bufv
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prim <= '0;
            bufv <= '0;
        end else if (clr) begin
            prim <= '0;
            bufv <= '0;
        end else if (fire) begin
            prim <= cnt;
            if (buf_en) bufv <= prim;
        end
    end

    // R2: counter steps by one each clock
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == $past(cnt) + 1'b1);
    // R7: chaining moves the old primary value into the buffer
    a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && buf_en && !clr) |=> bufv == $past(prim));
    // R8: with chaining off the buffer holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en && !clr) |=> bufv == $past(bufv));
    // R9: clear empties both registers
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (prim == '0 && bufv == '0));
endmodule

// File: rtl/cap_read.sv
module cap_read #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] prim,
    input  logic [W-1:0] bufv,
    input  logic         rd_en,
    input  logic         rd_buf,
    input  logic         rd_byte,
    input  logic         rd_hi,
    output logic [W-1:0] rd_data
);
    localparam int HALF = W / 2;

    logic [W-1:0]    sel;
    logic [HALF-1:0] lo_q;
    logic            latch_lo;

    assign sel      = rd_buf ? bufv : prim;
    assign latch_lo = rd_en && rd_byte && rd_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lo_q <= '0;
        else if (clr)      lo_q <= '0;
        else if (latch_lo) lo_q <= sel[HALF-1:0];
    end

    always_comb begin
        if (!rd_byte)   rd_data = sel;
        else if (rd_hi) rd_data = {{(W-HALF){1'b0}}, sel[W-1:HALF]};
        else            rd_data = {{(W-HALF){1'b0}}, lo_q};
    end

    // R11: the latched byte follows the byte selected at the latching edge
    a_r11_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_lo && !clr) |=> lo_q == $past(sel[HALF-1:0]));
endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import cap_pkg::*;
#(
    parameter int W          = 16,
    parameter int SYNC_STAGE = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_req,
    input  logic         cap_in,
    input  logic [1:0]   edge_sel,
    input  logic         buf_en,
    input  logic         rd_en,
    input  logic         rd_buf,
    input  logic         rd_byte,
    input  logic         rd_hi,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] cnt_val
);
    logic         lvl_s;
    logic         fire;
    logic [W-1:0] prim, bufv;

    cap_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .dout(lvl_s)
    );

    cap_edge_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_s),
        .mode(edge_mode_e'(edge_sel)), .fire(fire)
    );

    cap_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(clr_req), .fire(fire),
        .buf_en(buf_en), .cnt(cnt_val), .prim(prim), .bufv(bufv)
    );

    cap_read #(.W(W)) u_read (
        .clk(clk), .rst_n(rst_n), .clr(clr_req), .prim(prim), .bufv(bufv),
        .rd_en(rd_en), .rd_buf(rd_buf), .rd_byte(rd_byte), .rd_hi(rd_hi),
        .rd_data(rd_data)
    );

    // R9: clear wins over a simultaneous capture
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && fire) |=> prim == '0);
endmodule

// File: tb/test_cap_unit.sv
module test_cap_unit;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_req = 1'b0;
    logic        cap_in = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        buf_en = 1'b1;
    logic        rd_en = 1'b0, rd_buf = 1'b0, rd_byte = 1'b0, rd_hi = 1'b0;
    logic [15:0] rd_data, cnt_val;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cap_unit i_cap_unit (
        .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .cap_in(cap_in),
        .edge_sel(edge_sel), .buf_en(buf_en), .rd_en(rd_en), .rd_buf(rd_buf),
        .rd_byte(rd_byte), .rd_hi(rd_hi), .rd_data(rd_data), .cnt_val(cnt_val)
    );

    // {edge_sel, level driven, capture expected}
    localparam logic [3:0] VEC [8] = '{
        4'b00_1_1, 4'b00_0_0, 4'b01_1_1, 4'b01_0_1,
        4'b10_1_0, 4'b10_0_1, 4'b11_1_1, 4'b11_0_0
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_word(input logic b, output logic [15:0] v);
        rd_buf = b; rd_byte = 1'b0; rd_hi = 1'b0;
        #0.5;
        v = rd_data;
    endtask

    // drive a level at negedge; return counter value expected in primary
    task automatic drive_edge(input logic lvl, output logic [15:0] snap);
        @(negedge clk); cap_in = lvl;
        @(posedge clk); @(posedge clk);
        @(negedge clk); snap = cnt_val;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] p_m, b_m, snap, v, c0;
        string tag;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 cnt", cnt_val, 16'h0);
        rd_word(1'b0, v); check("R1 prim", v, 16'h0);
        rd_word(1'b1, v); check("R1 buf", v, 16'h0);
        rst_n = 1'b1;

        // R2: counting
        @(negedge clk); c0 = cnt_val;
        @(negedge clk); check("R2 step", cnt_val, c0 + 16'd1);

        // vector walk: R3 R4 R5 R6 R7 R12
        p_m = 16'h0; b_m = 16'h0;
        foreach (VEC[i]) begin
            @(negedge clk); edge_sel = VEC[i][3:2];
            tag = (VEC[i][3:2] == 2'b01) ? "R4" : (VEC[i][3:2] == 2'b10) ? "R5" : "R3";
            drive_edge(VEC[i][1], snap);
            if (VEC[i][0]) begin  // R6 timing, R7 chaining
                b_m = p_m; p_m = snap;
            end                   // else R12-style: no change
            rd_word(1'b0, v); check({tag, " R6 prim"}, v, p_m);
            rd_word(1'b1, v); check({tag, " R7 buf"}, v, b_m);
            repeat (2) @(negedge clk);
        end

        // R12: steady level, no capture
        repeat (5) @(negedge clk);
        rd_word(1'b0, v); check("R12 steady", v, p_m);

        // R8: chaining disabled
        edge_sel = 2'b00; buf_en = 1'b0;
        drive_edge(1'b1, snap); p_m = snap;
        rd_word(1'b0, v); check("R8 prim", v, p_m);
        rd_word(1'b1, v); check("R8 buf", v, b_m);
        drive_edge(1'b0, snap);
        buf_en = 1'b1;

        // R10 / R11: byte pair read across a capture
        @(negedge clk);
        rd_buf = 1'b0; rd_byte = 1'b1; rd_hi = 1'b1; rd_en = 1'b1;
        #0.5; check("R10 hi byte", rd_data, {8'h00, p_m[15:8]});
        @(negedge clk); rd_en = 1'b0;
        drive_edge(1'b1, snap);
        rd_word(1'b0, v); check("R10 word new", v, snap);
        rd_buf = 1'b0; rd_byte = 1'b1; rd_hi = 1'b0;
        #0.5; check("R11 lo byte", rd_data, {8'h00, p_m[7:0]});
        b_m = p_m; p_m = snap;

        // R9: clear
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        rd_word(1'b0, v); check("R9 prim", v, 16'h0);
        rd_word(1'b1, v); check("R9 buf", v, 16'h0);
        rd_byte = 1'b1; rd_hi = 1'b0;
        #0.5; check("R9 lo latch", rd_data, 16'h0);

        // R2: wrap
        @(negedge clk);
        while (cnt_val != 16'hFFFF) @(negedge clk);
        @(negedge clk); check("R2 wrap", cnt_val, 16'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule